// File: doc/BRIEF.md
# Overlapping Serial 1001 Recognizer

This block watches a serial bit stream, one bit per clock, and flags every place where the four most recent bits, counting the bit now on the input, read 1, 0, 0, 1 in arrival order. The flag is a Mealy output. It goes high during the same clock cycle in which the closing 1 is on the input, so the flag needs no extra stage of delay.

Matches may overlap. The closing 1 of one match can also open the next match, so the stream 1001001 produces two flags. Progress through the pattern is held in a two-bit state register, and that register is also brought out to the ports for debug. A parameter selects how the register is built. The default builds it from two behavioural JK cells, each driven by minimized excitation equations. The other option builds it from two D flops that load their next-state values directly. Both options must give the same results on every cycle.

Top module: `pd_seq_detect`

## Requirements
- R1: While rst_n is low, state_q reads 2'b00 and z_out is 0, whatever the value of x_in. The state stays at 2'b00 until the first rising clock edge after the internal reset release, which comes two edges after rst_n goes high.
- R2: state_q[1:0] = {Q1,Q0} uses these codes: 00 means nothing matched, 01 means "1" matched, 10 means "10" matched and 11 means "100" matched. From 00, x_in=0 stays in 00 and x_in=1 goes to 01.
- R3: From 01, x_in=0 goes to 10 and x_in=1 stays in 01. From 10, x_in=0 goes to 11 and x_in=1 goes to 01.
- R4: From 11, x_in=0 goes to 00. x_in=1 raises z_out and goes to 01.
- R5: z_out is high only while state_q is 11 and x_in is 1, in the same cycle, with no register between x_in and z_out.
- R6: Overlapping matches are all reported: the stream 1001001 after reset gives exactly two cycles with z_out high.
- R7: After reset, the input stream 11100110100100110 gives the output stream 00000100000100100, one bit per clock.
- R8: With USE_JK=0 (D flops), z_out and state_q equal those of USE_JK=1 (JK cells) on every cycle for the same inputs.
- R9: In every cycle, z_out is 1 exactly when the last three bits taken since reset, followed by the current x_in, form 1001.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| x_in | input | 1 | Serial data bit, one per clock |
| z_out | output | 1 | Match flag, combinational from state and x_in |
| state_q | output | 2 | Current state {Q1,Q0} for debug |

## Verification
z_out is combinational from the registered state and x_in, so it is valid in the cycle where the bit is presented. state_q changes at the next rising edge. The bench changes x_in at the falling edge and samples z_out 2 ns later, within the same cycle. It moves its arithmetic model on only after the following rising edge, so each state comparison looks at the value loaded by that edge. After rst_n goes high, the bench waits four cycles with x_in low, which covers the two-stage release, and only then starts to compare the stream.

// File: rtl/pd_pkg.sv
package pd_pkg;
  localparam int unsigned ST_W = 2;
  typedef logic [ST_W-1:0] st_t;
  localparam st_t ST_IDLE  = 2'b00;
  localparam st_t ST_ONE   = 2'b01;
  localparam st_t ST_ONE0  = 2'b10;
  localparam st_t ST_ONE00 = 2'b11;
endpackage

// File: rtl/pd_rst_sync.sv
module pd_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb sh_d = {sh_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/pd_jk_cell.sv
module pd_jk_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic j,
  input  logic k,
  output logic q
);
  logic q_nxt;

  always_comb begin
    unique case ({j, k})
      2'b00:   q_nxt = q;
      2'b01:   q_nxt = 1'b0;
      2'b10:   q_nxt = 1'b1;
      default: q_nxt = ~q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= q_nxt;
  end

  AST_JK_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (j && k) |=> (q != $past(q)));                                   // R8
  AST_JK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!j && !k) |=> $stable(q));                                      // R8
endmodule

// File: rtl/pd_excite.sv
module pd_excite
  import pd_pkg::*;
(
  input  st_t  q,
  input  logic x,
  output logic [ST_W-1:0] j,
  output logic [ST_W-1:0] k
);
  always_comb begin
    j[1] = ~x & q[0];
    k[1] =  x | q[0];
    j[0] =  x | q[1];
    k[0] = ~x;
  end
endmodule

// File: rtl/pd_dnext.sv
module pd_dnext
  import pd_pkg::*;
(
  input  st_t  q,
  input  logic x,
  output st_t  d
);
  always_comb begin
    unique case (q)
      ST_IDLE:  d = x ? ST_ONE : ST_IDLE;
      ST_ONE:   d = x ? ST_ONE : ST_ONE0;
      ST_ONE0:  d = x ? ST_ONE : ST_ONE00;
      default:  d = x ? ST_ONE : ST_IDLE;
    endcase
  end
endmodule

// File: rtl/pd_seq_detect.sv
module pd_seq_detect
  import pd_pkg::*;
#(
  parameter bit USE_JK = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            x_in,
  output logic            z_out,
  output logic [ST_W-1:0] state_q
);
  logic rst_i_n;
  st_t  st;

  pd_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  generate
    if (USE_JK) begin : g_jk
      logic [ST_W-1:0] jv;
      logic [ST_W-1:0] kv;
      pd_excite u_exc (.q(st), .x(x_in), .j(jv), .k(kv));
      for (genvar b = 0; b < ST_W; b++) begin : g_bit
        pd_jk_cell u_cell (
          .clk(clk), .rst_n(rst_i_n), .j(jv[b]), .k(kv[b]), .q(st[b])
        );
      end
    end else begin : g_d
      st_t st_d;
      pd_dnext u_nxt (.q(st), .x(x_in), .d(st_d));
      always_ff @(posedge clk or negedge rst_i_n) begin
        if (!rst_i_n) st <= ST_IDLE;
        else          st <= st_d;
      end
    end
  endgenerate

  assign z_out   = st[1] & st[0] & x_in;
  assign state_q = st;

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_i_n)
    (st == ST_IDLE && !x_in) |=> (st == ST_IDLE));                   // R2
  AST_IDLE_ADV: assert property (@(posedge clk) disable iff (!rst_i_n)
    (st == ST_IDLE && x_in) |=> (st == ST_ONE));                     // R2
  AST_MID_ZERO: assert property (@(posedge clk) disable iff (!rst_i_n)
    ((st == ST_ONE || st == ST_ONE0) && !x_in) |=> (st == $past(st) + 2'd1)); // R3
  AST_ONE_RESTART: assert property (@(posedge clk) disable iff (!rst_i_n)
    x_in |=> (st == ST_ONE));                                        // R3
  AST_LAST_DROP: assert property (@(posedge clk) disable iff (!rst_i_n)
    (st == ST_ONE00 && !x_in) |=> (st == ST_IDLE));                  // R4
  AST_HIT_OVERLAP: assert property (@(posedge clk) disable iff (!rst_i_n)
    z_out |=> (st == ST_ONE && $past(st) == ST_ONE00));              // R4
  AST_HIT_NEEDS_X: assert property (@(posedge clk) disable iff (!rst_i_n)
    z_out |-> x_in);                                                 // R5
  AST_RST_QUIET: assert property (@(posedge clk)
    !rst_i_n |-> !z_out);                                            // R1
endmodule

// File: tb/pd_seq_detect_tb.sv
module pd_seq_detect_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic x_in = 1'b0;
  logic z_jk, z_d;
  logic [1:0] s_jk, s_d;
  int n_cmp = 0;
  int n_bad = 0;
  logic [2:0] hist = '0;
  int hits = 0;

  always #10 clk = ~clk;

  pd_seq_detect #(.USE_JK(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .x_in(x_in), .z_out(z_jk), .state_q(s_jk));
  pd_seq_detect #(.USE_JK(1'b0)) u_dut_d (
    .clk(clk), .rst_n(rst_n), .x_in(x_in), .z_out(z_d), .state_q(s_d));

  function automatic logic [1:0] model_st(input logic [2:0] h);
    if (h == 3'b100)      return 2'b11;
    if (h[1:0] == 2'b10)  return 2'b10;
    if (h[0])             return 2'b01;
    return 2'b00;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; x_in = 1'b1;
    #2;
    chk("R1 state", s_jk, 0); chk("R1 z", z_jk, 0);
    chk("R1 state D", s_d, 0); chk("R1 z D", z_d, 0);
    @(negedge clk); rst_n = 1'b1; x_in = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1 idle after release", s_jk, 0);
    hist = '0;
  endtask

  task automatic step(input logic b, output logic zo);
    logic [1:0] ms;
    logic ez;
    string tg;
    @(negedge clk); x_in = b;
    #2;
    ms = model_st(hist);
    ez = ({hist, b} == 4'b1001);
    tg = (ms == 2'b00) ? "R2" : (ms == 2'b11) ? "R4" : "R3";
    chk(tg, s_jk, ms);
    chk("R9", z_jk, ez);
    chk("R5", z_jk, (s_jk == 2'b11) && b);
    chk("R8 z", z_d, z_jk);
    chk("R8 state", s_d, s_jk);
    zo = z_jk;
    hist = {hist[1:0], b};
  endtask

  initial begin
    logic zo;
    logic [16:0] got;
    logic [16:0] stim;
    logic [6:0] ov;
    do_reset();

    stim = 17'b11100110100100110;
    for (int i = 16; i >= 0; i--) begin
      step(stim[i], zo);
      got[i] = zo;
    end
    chk("R7 stream", got, 17'b00000100000100100);

    do_reset();
    ov = 7'b1001001; hits = 0;
    for (int i = 6; i >= 0; i--) begin
      step(ov[i], zo);
      if (zo) hits++;
    end
    chk("R6 overlap count", hits, 2);

    for (int p = 0; p < 256; p++) begin
      do_reset();
      for (int i = 7; i >= 0; i--) step(p[i], zo);
    end

    do_reset();
    for (int i = 0; i < 1200; i++) step(1'($urandom_range(0, 1)), zo);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(20 * 190000);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule